// File: doc/BRIEF.md
# Shared-Strobe ROM Bank Read Controller

This controller sits on the host side of a bank of ROM devices. The devices share one address bus, one 16-bit data bus, one width-select line and one output-enable strobe. The host sends one read at a time through a valid/ready port, as a byte address plus a width flag. The controller decodes the top address bits into one active-low select for the target device. Every other device is held deselected so that it stays in low-power standby. The controller pulls the shared output-enable low only for the last part of the access, captures the bus and returns the result as a one-cycle response.

Timing comes from cycle-count parameters rather than nanoseconds. ACC_CYC is the address and select access. OE_CYC is the output-enable access. FLOAT_CYC is the time a device needs to release the bus after its strobe rises. A read to the device that is already selected keeps its select low and changes only the address. A read to a different device must first wait until the shared strobe has been high for FLOAT_CYC cycles, so two devices never drive the bus at the same time.

Top module: `rbc_bank_reader`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, every mem_ce_no bit is 1, mem_oe_no is 1, req_ready_o is 1 and rsp_valid_o is 0.
- R2: At most one mem_ce_no bit is low at any time. The selected device index is req_addr_i[ADDR_W-1 -: SEL_W], and mem_ce_no bit i belongs to device i.
- R3: mem_oe_no is low only while a device select is low. In each access it is low for exactly the last OE_CYC cycles before data capture.
- R4: Address, width lines and select are held unchanged for ACC_CYC cycles before capture. When no float wait is needed, rsp_valid_o rises ACC_CYC clock edges after the edge that accepted the request.
- R5: In word mode (req_byte_i=0), mem_word_o is 1 and rsp_data_o carries all 16 bus bits. req_addr_i[0] is ignored.
- R6: In byte mode (req_byte_i=1), mem_word_o is 0 and mem_lsb_o equals req_addr_i[0] (1 selects the upper byte of the stored word). rsp_data_o[7:0] is bus bits 7:0 and rsp_data_o[15:8] is 0.
- R7: A new device select goes low only after mem_oe_no has been high for at least FLOAT_CYC cycles. No two devices ever drive or float on the bus together.
- R8: Consecutive reads to the same device keep that device's select low throughout. Each read still waits the full ACC_CYC.
- R9: req_ready_o is low from acceptance until the response. rsp_valid_o is a single-cycle pulse, and every accepted request gets exactly one response, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_addr_i | input | ADDR_W | Byte address: device index, word address, byte lane |
| req_byte_i | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid_o | output | 1 | Read data valid, one cycle |
| rsp_data_o | output | 16 | Read data |
| mem_addr_o | output | WORD_AW | Shared word address bus |
| mem_lsb_o | output | 1 | Byte-lane select in byte mode |
| mem_word_o | output | 1 | Shared width select, 1 = word |
| mem_ce_no | output | N_DEV | Per-device select, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_data_i | input | 16 | Shared data bus |

## Verification
The hardest case to reach is a request for a different device that arrives while the shared strobe has only just risen. This is the only point where the float wait changes the timing. The bench issues such a request straight after a response, so that acceptance lands one cycle after the strobe rises. The bench's device model keeps a released device "driving" for FLOAT_CYC cycles and returns garbage whenever the access or strobe time is cut short. A missing gap or a truncated access therefore shows up in the data or as a bus clash.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GAP    = 2'd1,
    ST_ACCESS = 2'd2
  } rbc_state_e;
endpackage

// File: rtl/rbc_ce_decode.sv
module rbc_ce_decode #(
  parameter int N_DEV = 4,
  parameter int SEL_W = 2
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] idx_i,
  output logic [N_DEV-1:0] ce_no
);
  for (genvar i = 0; i < N_DEV; i++) begin : g_ce
    assign ce_no[i] = !(en_i && (idx_i == SEL_W'(i)));
  end
endmodule

// File: rtl/rbc_float_timer.sv
module rbc_float_timer #(
  parameter int FLOAT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic float_ok_o
);
  localparam int CW = $clog2(FLOAT_CYC + 1);
  logic [CW-1:0] cnt_q;

  // cycles the shared strobe has been high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= CW'(FLOAT_CYC);
    else if (!oe_n_i)                 cnt_q <= '0;
    else if (cnt_q != CW'(FLOAT_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign float_ok_o = (cnt_q == CW'(FLOAT_CYC));
endmodule

// File: rtl/rbc_bank_reader.sv
module rbc_bank_reader import rbc_pkg::*; #(
  parameter int N_DEV     = 4,
  parameter int WORD_AW   = 10,
  parameter int ACC_CYC   = 4,
  parameter int OE_CYC    = 2,
  parameter int FLOAT_CYC = 2,
  localparam int SEL_W    = $clog2(N_DEV),
  localparam int ADDR_W   = SEL_W + WORD_AW + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic               req_byte_i,
  output logic               rsp_valid_o,
  output logic [15:0]        rsp_data_o,
  output logic [WORD_AW-1:0] mem_addr_o,
  output logic               mem_lsb_o,
  output logic               mem_word_o,
  output logic [N_DEV-1:0]   mem_ce_no,
  output logic               mem_oe_no,
  input  logic [15:0]        mem_data_i
);
  localparam int CNT_W   = $clog2(ACC_CYC + 1);
  localparam int OE_LEAD = ACC_CYC - OE_CYC;

  rbc_state_e         state_q;
  logic [SEL_W-1:0]   dev_q;
  logic               open_q;
  logic [WORD_AW-1:0] waddr_q;
  logic               lsb_q, word_q, oe_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  lat_addr_q;
  logic               lat_byte_q;
  logic               rsp_valid_q;
  logic [15:0]        rsp_data_q;
  logic               float_ok;

  logic [ADDR_W-1:0]  src_addr;
  logic               src_byte, same_dev, launch;
  logic [SEL_W-1:0]   src_dev;

  rbc_ce_decode #(.N_DEV(N_DEV), .SEL_W(SEL_W)) u_dec (
    .en_i (open_q),
    .idx_i(dev_q),
    .ce_no(mem_ce_no)
  );

  rbc_float_timer #(.FLOAT_CYC(FLOAT_CYC)) u_float (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .oe_n_i    (oe_q),
    .float_ok_o(float_ok)
  );

  always_comb begin
    src_addr = (state_q == ST_GAP) ? lat_addr_q : req_addr_i;
    src_byte = (state_q == ST_GAP) ? lat_byte_q : req_byte_i;
    src_dev  = src_addr[ADDR_W-1 -: SEL_W];
    same_dev = open_q && (src_dev == dev_q);
    launch   = ((state_q == ST_IDLE) && req_valid_i && (same_dev || float_ok)) ||
               ((state_q == ST_GAP) && float_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      dev_q       <= '0;
      open_q      <= 1'b0;
      waddr_q     <= '0;
      lsb_q       <= 1'b0;
      word_q      <= 1'b1;
      oe_q        <= 1'b1;
      cnt_q       <= '0;
      lat_addr_q  <= '0;
      lat_byte_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (launch) begin
        dev_q   <= src_dev;
        open_q  <= 1'b1;
        waddr_q <= src_addr[WORD_AW:1];
        lsb_q   <= src_byte & src_addr[0];
        word_q  <= !src_byte;
        cnt_q   <= '0;
        oe_q    <= (OE_LEAD != 0);
        state_q <= ST_ACCESS;
      end else begin
        case (state_q)
          ST_IDLE: if (req_valid_i) begin
            // switch needs float spacing: release old select now
            lat_addr_q <= req_addr_i;
            lat_byte_q <= req_byte_i;
            open_q     <= 1'b0;
            state_q    <= ST_GAP;
          end
          ST_ACCESS: begin
            if (cnt_q == CNT_W'(ACC_CYC - 1)) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= word_q ? mem_data_i : {8'h00, mem_data_i[7:0]};
              oe_q        <= 1'b1;
              state_q     <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
              oe_q  <= !((int'(cnt_q) + 1) >= OE_LEAD);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
  assign mem_addr_o  = waddr_q;
  assign mem_lsb_o   = lsb_q;
  assign mem_word_o  = word_q;
  assign mem_oe_no   = oe_q;

  p_one_select_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_ce_no));

  p_oe_needs_select_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (~mem_ce_no != '0));

  p_bus_steady_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no && $past(!mem_oe_no)) |->
      ($stable(mem_addr_o) && $stable(mem_ce_no) && $stable(mem_lsb_o) && $stable(mem_word_o)));

  p_byte_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !mem_word_o) |-> (rsp_data_o[15:8] == 8'h00));

  p_new_select_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~mem_ce_no & $past(mem_ce_no)) != '0) |-> $past(float_ok));

  p_rsp_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_ready_strobe_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> mem_oe_no);
endmodule

// File: tb/tb_rbc_bank_reader.sv
module tb_rbc_bank_reader;
  localparam int CLK_PERIOD = 10;
  localparam int N_DEV      = 4;
  localparam int WORD_AW    = 10;
  localparam int ACC_CYC    = 4;
  localparam int OE_CYC     = 2;
  localparam int FLOAT_CYC  = 2;
  localparam int SEL_W      = 2;
  localparam int ADDR_W     = SEL_W + WORD_AW + 1;
  localparam int WDOG       = 20000;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               req_valid, req_byte;
  logic [ADDR_W-1:0]  req_addr;
  logic               req_ready_o, rsp_valid_o;
  logic [15:0]        rsp_data_o;
  logic [WORD_AW-1:0] mem_addr_o;
  logic               mem_lsb_o, mem_word_o, mem_oe_no;
  logic [N_DEV-1:0]   mem_ce_no;
  logic [15:0]        mem_data = 16'hFFFF;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  rbc_bank_reader #(.N_DEV(N_DEV), .WORD_AW(WORD_AW), .ACC_CYC(ACC_CYC),
                    .OE_CYC(OE_CYC), .FLOAT_CYC(FLOAT_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr), .req_byte_i(req_byte), .rsp_valid_o(rsp_valid_o),
    .rsp_data_o(rsp_data_o), .mem_addr_o(mem_addr_o), .mem_lsb_o(mem_lsb_o),
    .mem_word_o(mem_word_o), .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no),
    .mem_data_i(mem_data));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [15:0] data;
    int acc;
    bit exact;
    int dev;
    bit keep;
    bit bmode;
  } exp_t;
  exp_t sb[$];

  function automatic logic [15:0] pat(int dev, logic [WORD_AW-1:0] wa);
    return 16'(dev * 16'h1111) ^ {wa, 6'b010101};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // driver: issue a read, push expected result
  task automatic rd(int dev, int wa, bit b, bit b0, bit exact, bit keep);
    exp_t e;
    logic [15:0] f;
    @(negedge clk);
    req_addr  = {2'(dev), 10'(wa), b0};
    req_byte  = b;
    req_valid = 1'b1;
    while (!req_ready_o) @(negedge clk);
    f = pat(dev, 10'(wa));
    e.data  = b ? {8'h00, (b0 ? f[15:8] : f[7:0])} : f;
    e.acc   = cyc + 1;
    e.exact = exact;
    e.dev   = dev;
    e.keep  = keep;
    e.bmode = b;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready_o == 1'b0, "R9 ready low while busy", req_ready_o, 0);
  endtask

  // device model, bus float tracking, monitor
  logic [N_DEV-1:0] prev_ce = '1;
  logic [N_DEV-1:0] prev_drv = '0;
  logic [N_DEV+WORD_AW+1:0] prev_sig = '0;
  int age = 0, oe_age = 0, last_oe_len = 0, oe_hi_run = 1000;
  int float_left[N_DEV];
  int ce_run[N_DEV];
  bit prev_rsp = 0;
  initial for (int d = 0; d < N_DEV; d++) begin float_left[d] = 0; ce_run[d] = 0; end

  always @(negedge clk) begin
    logic [N_DEV+WORD_AW+1:0] sig;
    int nsel, sel;
    logic [15:0] f;
    exp_t e;
    sig = {mem_ce_no, mem_addr_o, mem_lsb_o, mem_word_o};
    age = (sig == prev_sig) ? age + 1 : 1;
    prev_sig = sig;
    if (!mem_oe_no) oe_age = oe_age + 1;
    else begin
      if (oe_age != 0) last_oe_len = oe_age;
      oe_age = 0;
    end
    nsel = 0; sel = 0;
    for (int d = 0; d < N_DEV; d++) begin
      ce_run[d] = mem_ce_no[d] ? 0 : ce_run[d] + 1;
      if (!mem_ce_no[d]) begin nsel++; sel = d; end
    end
    if (rst_n) begin
      if ((~mem_ce_no & prev_ce) != '0)
        chk(oe_hi_run >= FLOAT_CYC, "R7 strobe-high cycles before new select", oe_hi_run, FLOAT_CYC);
      if (!mem_oe_no) chk(nsel == 1, "R3 strobe low with one select", nsel, 1);
      if (nsel > 1) chk(0, "R2 select count", nsel, 1);
      for (int d = 0; d < N_DEV; d++) begin
        if (!mem_ce_no[d] && !mem_oe_no && !prev_drv[d])
          for (int k = 0; k < N_DEV; k++)
            if (k != d) chk(float_left[k] == 0, "R7 bus clash with floating device", k, d);
      end
    end
    for (int d = 0; d < N_DEV; d++) begin
      if (!mem_ce_no[d] && !mem_oe_no) float_left[d] = FLOAT_CYC;
      else if (float_left[d] > 0) float_left[d] = float_left[d] - 1;
      prev_drv[d] = !mem_ce_no[d] && !mem_oe_no;
    end
    oe_hi_run = mem_oe_no ? oe_hi_run + 1 : 0;
    prev_ce = mem_ce_no;

    if (rst_n && rsp_valid_o) begin
      chk(!prev_rsp, "R9 response single pulse", prev_rsp, 0);
      if (sb.size() == 0) chk(0, "R9 unexpected response", rsp_data_o, 0);
      else begin
        e = sb.pop_front();
        chk(rsp_data_o == e.data, e.bmode ? "R6 byte data" : "R5 word data", rsp_data_o, e.data);
        if (e.exact) chk(cyc == e.acc + ACC_CYC, "R4 latency", cyc - e.acc, ACC_CYC);
        else         chk(cyc >= e.acc + ACC_CYC, "R4 minimum latency", cyc - e.acc, ACC_CYC);
        chk(mem_ce_no == ~(N_DEV'(1) << e.dev), "R2 decoded select", mem_ce_no, ~(N_DEV'(1) << e.dev));
        chk(mem_word_o == !e.bmode, "R5 R6 width line", mem_word_o, !e.bmode);
        chk(last_oe_len == OE_CYC, "R3 strobe length", last_oe_len, OE_CYC);
        if (e.keep) chk(ce_run[e.dev] >= ACC_CYC + 2, "R8 select held across reads", ce_run[e.dev], ACC_CYC + 2);
      end
    end
    prev_rsp = rsp_valid_o;

    // drive the bus for the next capture edge
    if (!mem_oe_no && nsel == 1) begin
      if (age >= ACC_CYC && oe_age >= OE_CYC) begin
        f = pat(sel, mem_addr_o);
        mem_data = mem_word_o ? f : {8'hA5, (mem_lsb_o ? f[15:8] : f[7:0])};
      end else mem_data = 16'hDEAD;
    end else mem_data = 16'hFFFF;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_byte = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_no == '1, "R1 selects idle in reset", mem_ce_no, 4'hF);
    chk(mem_oe_no == 1'b1, "R1 strobe idle in reset", mem_oe_no, 1);
    chk(req_ready_o == 1'b1, "R1 ready in reset", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R1 no response in reset", rsp_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_no == '1 && mem_oe_no, "R1 idle after reset", {mem_ce_no, mem_oe_no}, 5'h1F);

    rd(0, 10'h005, 0, 0, 1, 0);
    rd(0, 10'h123, 0, 0, 1, 1);   // R8 same device
    rd(0, 10'h3FF, 0, 1, 1, 1);   // R5 bit 0 ignored
    rd(0, 10'h000, 0, 0, 1, 1);
    rd(2, 10'h2AA, 0, 0, 0, 0);   // R7 switch right after strobe rise
    rd(2, 10'h2AB, 1, 0, 1, 1);   // R6 low byte
    rd(2, 10'h2AB, 1, 1, 1, 1);   // R6 high byte
    rd(1, 10'h011, 1, 1, 0, 0);
    rd(3, 10'h1C3, 0, 0, 0, 0);
    repeat (10) @(negedge clk);
    rd(1, 10'h0F0, 0, 0, 1, 0);   // R7 switch after long idle: no wait
    rd(1, 10'h0F0, 1, 1, 1, 1);
    for (int i = 0; i < 12; i++) rd(i % N_DEV, i * 37, i[0], i[1], 0, 0);
    repeat (30) @(negedge clk);
    chk(sb.size() == 0, "R9 every request answered", sb.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule